// File: doc/BRIEF.md
# USB Host Port Reset Controller

This block holds the control and status register of a single USB host port and times the bus reset in hardware. Software asks for a reset by writing one bit. The block then drives reset on the port for a fixed number of microsecond ticks, 10 ms by default. When the count ends it clears the bit itself, enables the port, latches the speed the PHY has negotiated and raises a change flag. Software never has to clear the reset bit. If it tries to clear the bit early, the write is discarded and the reset runs to completion.

Attach and detach are taken from a connect input driven by the PHY. A detach during a reset aborts that reset. Two write-one-to-clear change flags feed a single interrupt line, which is gated by an enable bit in a second register. The speed is reported in two ways: a two-bit field, and a high-speed flag that always agrees with it. A pair of PHY mode bits is held in the port register and driven straight out to the PHY. There is no ownership hand-off, so the owner bit always reads 0.

Top module: `hprt_ctrl`

## Requirements
- R1: After synchronous reset, both registers read 0, `port_rst_drv` is 0, `irq` is 0 and `phy_mode` is 0.
- R2: A rising `phy_conn` sets the connect status (port register bit 0) and the connect-change flag (bit 1) at the next clock edge.
- R3: A write to the port register (address 0) with bit 4 set, made while the port is connected, starts a reset. From the next edge, bit 4 and `port_rst_drv` read 1 and the enable bit (bit 2) reads 0. The same write made while disconnected has no effect.
- R4: A reset lasts exactly `RST_TICKS` cycles in which `tick` is high. At the edge that takes the last of these ticks, bit 4 and `port_rst_drv` fall, the enable bit (bit 2) and the enable-change flag (bit 3) are set, and the speed is latched from `phy_speed`.
- R5: While a reset is running, a write of 0 to bit 4 is ignored, and a write of 1 to bit 4 does not restart the count.
- R6: A falling `phy_conn` aborts any reset in progress. At the next edge, bits 0, 2, 4 and the speed read 0, and the connect-change flag is set.
- R7: The speed field (bits 7:6) encodes 00 as full speed, 01 as low speed and 10 as high speed. The high-speed flag (bit 8) reads 1 exactly when the field reads 10.
- R8: The owner bit (bit 5) always reads 0, including after a write of 1 to it.
- R9: Bits 1 and 3 clear when 1 is written to them. Writing 0 to them leaves them unchanged.
- R10: `irq` is high exactly when the interrupt-enable bit (address 1, bit 0) is 1 and at least one of bits 1 and 3 is 1.
- R11: Port register bits 11:10 can be written and read back, and they drive `phy_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | ADDR_W | Register address: 0 is the port register, 1 is the control register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tick | input | 1 | One-cycle pulse every microsecond |
| phy_conn | input | 1 | Device connected, as seen by the PHY |
| phy_speed | input | 2 | Speed negotiated by the PHY |
| phy_mode | output | 2 | PHY operating mode selection |
| port_rst_drv | output | 1 | Drive bus reset on the port |
| irq | output | 1 | Port change interrupt |

## Verification
The bench builds the block with `RST_TICKS` set to 12. A complete reset then takes only a dozen tick pulses, so many reset cycles fit in one run. The boundary between the next-to-last and the last tick can be checked directly, and randomly placed detaches, early clears and repeated start writes can land at every point of the count. The address width stays at its default of 2, so the bench also reads one unmapped address.

// File: rtl/hprt_pkg.sv
package hprt_pkg;

    localparam int DATA_W = 32;

    // Port register bit positions
    localparam int B_CONN   = 0;
    localparam int B_CCHG   = 1;
    localparam int B_EN     = 2;
    localparam int B_ECHG   = 3;
    localparam int B_RST    = 4;
    localparam int B_OWNER  = 5;
    localparam int B_SPD_LO = 6;
    localparam int B_HS     = 8;
    localparam int B_MODE_LO = 10;

    // Control register bit positions
    localparam int B_IRQ_EN = 0;

    typedef enum logic [1:0] {
        SPD_FULL = 2'b00,
        SPD_LOW  = 2'b01,
        SPD_HIGH = 2'b10,
        SPD_RSVD = 2'b11
    } speed_e;

    typedef struct packed {
        logic       conn;
        logic       conn_chg;
        logic       en;
        logic       en_chg;
        logic       rst;
        speed_e     spd;
        logic       hs;
        logic [1:0] mode;
    } port_stat_t;

    function automatic logic [DATA_W-1:0] pack_port(input port_stat_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_CONN]  = s.conn;
        w[B_CCHG]  = s.conn_chg;
        w[B_EN]    = s.en;
        w[B_ECHG]  = s.en_chg;
        w[B_RST]   = s.rst;
        w[B_OWNER] = 1'b0;
        w[B_SPD_LO +: 2] = s.spd;
        w[B_HS]    = s.hs;
        w[B_MODE_LO +: 2] = s.mode;
        return w;
    endfunction

endpackage

// File: rtl/hprt_conn_mon.sv
module hprt_conn_mon (
    input  logic clk,
    input  logic rst,
    input  logic phy_conn,
    output logic conn_q,
    output logic attach,
    output logic detach
);
    always_ff @(posedge clk) begin
        if (rst) conn_q <= 1'b0;
        else     conn_q <= phy_conn;
    end

    assign attach = phy_conn & ~conn_q;
    assign detach = ~phy_conn & conn_q;

    // R6: a detach edge leaves the registered status low
    assert_detach_drops_R6: assert property (@(posedge clk) disable iff (rst)
        detach |=> !conn_q);
endmodule

// File: rtl/hprt_rst_timer.sv
module hprt_rst_timer #(
    parameter int RST_TICKS = 10000,
    localparam int CNT_W = $clog2(RST_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    input  logic tick,
    output logic active,
    output logic done
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_TICKS - 1);

    logic [CNT_W-1:0] cnt;
    logic             last_tick;

    assign last_tick = active & tick & (cnt == LAST);
    assign done      = last_tick & ~abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (abort) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            if (tick) begin
                if (cnt == LAST) begin
                    active <= 1'b0;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end
    end

    // R4: the count never passes the terminal value
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    // R5: a running reset only ends by completion or abort
    assert_hold_active_R5: assert property (@(posedge clk) disable iff (rst)
        (active && !last_tick && !abort) |=> active);
    // R6: abort always stops the timer
    assert_abort_stops_R6: assert property (@(posedge clk) disable iff (rst)
        abort |=> !active);
endmodule

// File: rtl/hprt_ctrl.sv
module hprt_ctrl
    import hprt_pkg::*;
#(
    parameter int RST_TICKS = 10000,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick,
    input  logic              phy_conn,
    input  logic [1:0]        phy_speed,
    output logic [1:0]        phy_mode,
    output logic              port_rst_drv,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_PORT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);

    logic       conn_q, attach, detach;
    logic       t_active, t_done, t_start;
    logic       wr_port, wr_ctrl;
    logic       cchg_q, en_q, echg_q, hs_q, irq_en_q;
    speed_e     spd_q;
    logic [1:0] mode_q;
    port_stat_t stat;

    hprt_conn_mon u_mon (
        .clk      (clk),
        .rst      (rst),
        .phy_conn (phy_conn),
        .conn_q   (conn_q),
        .attach   (attach),
        .detach   (detach)
    );

    assign wr_port = bus_sel & bus_we & (bus_addr == A_PORT);
    assign wr_ctrl = bus_sel & bus_we & (bus_addr == A_CTRL);
    assign t_start = wr_port & bus_wdata[B_RST] & conn_q & ~detach & ~t_active;

    hprt_rst_timer #(.RST_TICKS(RST_TICKS)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (t_start),
        .abort  (detach),
        .tick   (tick),
        .active (t_active),
        .done   (t_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cchg_q   <= 1'b0;
            en_q     <= 1'b0;
            echg_q   <= 1'b0;
            spd_q    <= SPD_FULL;
            hs_q     <= 1'b0;
            mode_q   <= '0;
            irq_en_q <= 1'b0;
        end else begin
            if (attach || detach)
                cchg_q <= 1'b1;
            else if (wr_port && bus_wdata[B_CCHG])
                cchg_q <= 1'b0;

            if (t_done)
                echg_q <= 1'b1;
            else if (wr_port && bus_wdata[B_ECHG])
                echg_q <= 1'b0;

            if (detach)
                en_q <= 1'b0;
            else if (t_done)
                en_q <= 1'b1;
            else if (t_start)
                en_q <= 1'b0;

            if (detach) begin
                spd_q <= SPD_FULL;
                hs_q  <= 1'b0;
            end else if (t_done) begin
                spd_q <= speed_e'(phy_speed);
                hs_q  <= (phy_speed == SPD_HIGH);
            end

            if (wr_port) mode_q   <= bus_wdata[B_MODE_LO +: 2];
            if (wr_ctrl) irq_en_q <= bus_wdata[B_IRQ_EN];
        end
    end

    always_comb begin
        stat.conn     = conn_q;
        stat.conn_chg = cchg_q;
        stat.en       = en_q;
        stat.en_chg   = echg_q;
        stat.rst      = t_active;
        stat.spd      = spd_q;
        stat.hs       = hs_q;
        stat.mode     = mode_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_PORT)      bus_rdata = pack_port(stat);
        else if (bus_addr == A_CTRL) bus_rdata[B_IRQ_EN] = irq_en_q;
    end

    assign phy_mode     = mode_q;
    assign port_rst_drv = t_active;
    assign irq          = irq_en_q & (cchg_q | echg_q);

    // R7: the high-speed flag agrees with the speed field
    assert_hs_agree_R7: assert property (@(posedge clk) disable iff (rst)
        hs_q == (spd_q == SPD_HIGH));
    // R4: completion enables the port and flags the change
    assert_done_enables_R4: assert property (@(posedge clk) disable iff (rst)
        t_done |=> (en_q && echg_q && !port_rst_drv));
    // R6: detach clears enable and flags a connect change
    assert_detach_clears_R6: assert property (@(posedge clk) disable iff (rst)
        detach |=> (!en_q && cchg_q && !port_rst_drv));
    // R3: the port is never enabled while reset is driven
    assert_no_en_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
        port_rst_drv |-> !en_q);
endmodule

// File: tb/hprt_ctrl_tb.sv
module hprt_ctrl_tb;
    localparam int N = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick = 1'b0, phy_conn = 1'b0;
    logic [1:0]  phy_speed = '0;
    logic [1:0]  phy_mode;
    logic        port_rst_drv, irq;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hprt_ctrl #(.RST_TICKS(N), .ADDR_W(2)) u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick(tick), .phy_conn(phy_conn), .phy_speed(phy_speed),
        .phy_mode(phy_mode), .port_rst_drv(port_rst_drv), .irq(irq)
    );

    function automatic logic [31:0] exp_port(logic c, logic cc, logic e, logic ec,
                                             logic r, logic [1:0] s, logic [1:0] m);
        logic [31:0] w = '0;
        w[0] = c; w[1] = cc; w[2] = e; w[3] = ec; w[4] = r;
        w[7:6] = s; w[8] = (s == 2'b10); w[11:10] = m;
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic pulse_tick(int gap);
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic set_conn(logic v);
        @(negedge clk); phy_conn = v;
        @(negedge clk);
    endtask

    logic [31:0] d;
    logic [1:0]  md;

    initial begin
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        rst = 0;
        rd(0, d); chk("R1 port", d, 0);
        rd(1, d); chk("R1 ctrl", d, 0);
        chk("R1 pins", {29'd0, port_rst_drv, irq, phy_mode[0]}, 0);

        // disconnected reset request is ignored
        wr(0, 32'h10);
        rd(0, d); chk("R3 no conn", d, 0);
        chk("R3 drv idle", {31'd0, port_rst_drv}, 0);

        // mode bits and owner bit
        wr(0, 32'h0000_0C20);
        rd(0, d); chk("R11 mode", d, exp_port(0,0,0,0,0,0,2'b11));
        chk("R8 owner", {31'd0, d[5]}, 0);
        chk("R11 pin", {30'd0, phy_mode}, 32'd3);
        wr(0, 32'h0);
        md = 0;

        set_conn(1);
        rd(0, d); chk("R2 attach", d, exp_port(1,1,0,0,0,0,md));
        chk("R10 irq off", {31'd0, irq}, 0);
        wr(1, 1);
        chk("R10 irq on", {31'd0, irq}, 1);
        wr(0, 32'h0);
        rd(0, d); chk("R9 zero keeps", d[1], 1);
        wr(0, 32'h2);
        rd(0, d); chk("R9 w1c", d, exp_port(1,0,0,0,0,0,md));
        chk("R10 irq clr", {31'd0, irq}, 0);

        // directed full reset at boundary, high speed
        phy_speed = 2'b10;
        wr(0, 32'h10);
        rd(0, d); chk("R3 start", d, exp_port(1,0,0,0,1,0,md));
        chk("R3 drv", {31'd0, port_rst_drv}, 1);
        for (int i = 0; i < N-1; i++) pulse_tick(i % 3);
        wr(0, 32'h0);
        wr(0, 32'h10);
        rd(0, d); chk("R5 still active", d, exp_port(1,0,0,0,1,0,md));
        pulse_tick(0);
        rd(0, d); chk("R4 done HS", d, exp_port(1,0,1,1,0,2'b10,md));
        chk("R7 hs bit", {31'd0, d[8]}, 1);
        chk("R10 irq en chg", {31'd0, irq}, 1);
        wr(0, 32'h8);
        set_conn(0);
        rd(0, d); chk("R6 detach idle", d, exp_port(0,1,0,0,0,0,md));
        wr(0, 32'h2);
        rd(2, d); chk("R1 unmapped", d, 0);

        // random phase
        for (int it = 0; it < 40; it++) begin
            logic [1:0] s = 2'($urandom % 3);
            bit ab = ($urandom % 4) == 0;
            int cut = 1 + int'($urandom % (N-1));
            md = 2'($urandom);
            set_conn(1);
            wr(0, {20'd0, md, 10'd2});
            phy_speed = s;
            wr(0, {20'd0, md, 10'h10});
            rd(0, d); chk("R3 rand start", d, exp_port(1,0,0,0,1,0,md));
            for (int k = 0; k < (ab ? cut : N-1); k++) begin
                pulse_tick(int'($urandom % 3));
                if ($urandom % 3 == 0) wr(0, {20'd0, md, 10'h0});
            end
            if (ab) begin
                set_conn(0);
                rd(0, d); chk("R6 abort", d, exp_port(0,1,0,0,0,0,md));
                chk("R6 drv", {31'd0, port_rst_drv}, 0);
            end else begin
                rd(0, d); chk("R5 rand hold", d, exp_port(1,0,0,0,1,0,md));
                pulse_tick(0);
                rd(0, d); chk("R4 rand done", d, exp_port(1,0,1,1,0,s,md));
                chk("R7 rand hs", {31'd0, d[8]}, {31'd0, s == 2'b10});
                set_conn(0);
                rd(0, d); chk("R6 rand detach", d, exp_port(0,1,0,1,0,0,md));
            end
            wr(0, {20'd0, md, 10'h0A});
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule